// File: doc/BRIEF.md
# Configurable-Width ROM Read Port

This block is a clocked behavioural model of the read side of a one-time-programmable memory. It takes a 21-bit word address, a chip select and an output gate, both active low, and a width select. In word mode it presents a 16-bit word. In byte mode one pin changes role: the line that carries data bit 15 in word mode becomes the lowest address bit (`a_m1_i`). That bit picks the low or high half of the addressed word, which then appears on the low lane. An identification flag stands in for a forced high voltage on an address pin. While it is set, fixed identification codes replace the array data.

Each output lane is reported through a drive-enable signal, so the surrounding logic can build the tri-state pads. Access and float delays are parameters counted in clock edges. A valid strobe marks the cycles in which the presented data is settled. The storage is a small array that is loaded at reset from a computed pattern. Locations past the preloaded region read as erased.

The controller is a state machine with five states:
- ST_STANDBY: chip deselected, nothing driven.
- ST_OUTOFF: chip selected but the output gate is closed, nothing driven.
- ST_WAIT: drivers on, data not yet settled.
- ST_VALID: drivers on, data settled.
- ST_FLOAT: drivers still on for a bounded time after a release.

Its transitions are:
- enable: from ST_STANDBY or ST_OUTOFF to ST_WAIT, or straight to ST_VALID when the access timers are already met.
- settle: ST_WAIT to ST_VALID.
- disturb: ST_VALID to ST_WAIT on an address, half-select, width or identification change.
- release: ST_WAIT or ST_VALID to ST_FLOAT.
- float-done: ST_FLOAT to ST_STANDBY or ST_OUTOFF.
- re-enable: ST_FLOAT back to ST_WAIT or ST_VALID.

Top module: `cfgw_rom_port`

## Requirements
- R1: While reset is asserted and directly after it, `valid_o`, `drv_lo_o`, `drv_mid_o` and `drv_top_o` are all low.
- R2: Timing is counted from the first clock edge that samples a change. `valid_o` rises on the edge where the address (including width select, half select in byte mode and identification flag) has been stable for T_ADDR edges, the chip select has been low for T_CE edges and the output gate has been low for T_OE edges. The defaults are 6, 5 and 3. Whenever `valid_o` is high, `drv_lo_o` is high.
- R3: In word mode (`word_mode_i` = 1), `drv_lo_o`, `drv_mid_o` and `drv_top_o` are all high while driving, and `dq_o` carries the full 16-bit word.
- R4: In byte mode (`word_mode_i` = 0), `drv_mid_o` and `drv_top_o` stay low and `dq_o[15:8]` reads 0. `dq_o[7:0]` carries word bits 7:0 when `a_m1_i` = 0 and bits 15:8 when `a_m1_i` = 1.
- R5: With `ce_n_i` high, no lane is driven once the float time has passed, whatever `oe_n_i` does. `valid_o` is only ever high after an edge that sampled both `ce_n_i` and `oe_n_i` low.
- R6: With `ce_n_i` low and `oe_n_i` high, no lane is driven once the float time has passed. After `oe_n_i` falls again, with the chip select and address long stable, `valid_o` returns after T_OE edges.
- R7: When the chip select or the output gate rises while driving, `valid_o` drops on the first edge. The drivers stay on for T_FLOAT further cycles (default 2) and are off after edge T_FLOAT+1.
- R8: A change of address, of `a_m1_i` in byte mode, of the width select or of the identification flag drops `valid_o` on the first edge that samples it. Valid returns T_ADDR edges after that change.
- R9: With `id_force_i` = 1, address 0 reads 0x0020 and address 1 reads 0x0032. Any address with a bit above bit 0 set reads 0x0000. The upper byte is always 0.
- R10: Word location i below PRELOAD_WORDS (default 48) holds ((i XOR 0xA5) mod 256) in bits 15:8 and ((i + 0x3C) mod 256) in bits 7:0. All other addresses, including those at or beyond DEPTH (default 64), read 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 21 | Word address |
| a_m1_i | input | 1 | Half select (lowest address bit) in byte mode |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output gate, active low |
| word_mode_i | input | 1 | 1 = 16-bit words, 0 = bytes |
| id_force_i | input | 1 | Identification code mode |
| dq_o | output | 16 | Presented data |
| drv_lo_o | output | 1 | Drive enable, bits 7:0 |
| drv_mid_o | output | 1 | Drive enable, bits 14:8 |
| drv_top_o | output | 1 | Drive enable, bit 15 (dual-role pin) |
| valid_o | output | 1 | Presented data is settled |

## Verification
Every result is due a fixed number of edges after the bench drives a stimulus on a falling edge:
- A combined select-and-address start settles after max(T_ADDR, T_CE, T_OE) = 6 edges.
- An address or half-select change settles after T_ADDR = 6 edges.
- Reopening the output gate settles after T_OE = 3 edges.
- A release drops valid after 1 edge and removes the drivers after T_FLOAT+1 = 3 edges.

Each task advances exactly that many edges, and samples on the following falling edge both one edge before the due point, where valid must still be low, and at the due point itself. Data is compared only in cycles where valid is high.

// File: rtl/cfgw_rom_pkg.sv
package cfgw_rom_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_OUTOFF,
        ST_WAIT,
        ST_VALID,
        ST_FLOAT
    } port_state_e;

    localparam logic [7:0] MAKER_CODE = 8'h20;
    localparam logic [7:0] PART_CODE  = 8'h32;
    localparam logic [15:0] ERASED_WORD = 16'hFFFF;

    // Computed preload pattern for word location idx.
    function automatic logic [15:0] preload_word(input logic [31:0] idx);
        logic [7:0] b;
        b = idx[7:0];
        return {b ^ 8'hA5, b + 8'h3C};
    endfunction

endpackage

// File: rtl/cfgw_age_counter.sv
// Counts edges since a condition began, saturating at LIMIT.
module cfgw_age_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic restart_i,
    output logic met_o
);
    localparam int CNT_W = $clog2(LIMIT + 2);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (clear_i) begin
            cnt_d = '0;
        end else if (restart_i) begin
            cnt_d = CNT_W'(1);
        end else if (cnt_q >= LIM) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign met_o = (cnt_d >= LIM);

endmodule

// File: rtl/cfgw_rom_cells.sv
// Small storage array, loaded from the computed pattern at reset.
module cfgw_rom_cells
    import cfgw_rom_pkg::*;
#(
    parameter int ADDR_W        = 21,
    parameter int DEPTH         = 64,
    parameter int PRELOAD_WORDS = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [15:0]       rd_word_o
);
    localparam int IDX_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);
    localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W + 1)'(DEPTH);

    logic [15:0] cells_q [DEPTH];
    logic        in_range;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= (i < PRELOAD_WORDS) ? preload_word(32'(i)) : ERASED_WORD;
            end
        end
    end

    assign in_range  = ({1'b0, addr_i} < DEPTH_L);
    assign rd_word_o = in_range ? cells_q[addr_i[IDX_W-1:0]] : ERASED_WORD;

endmodule

// File: rtl/cfgw_port_fsm.sv
// Output-control state machine: drivers, valid strobe and data load.
module cfgw_port_fsm
    import cfgw_rom_pkg::*;
#(
    parameter int T_FLOAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    input  logic oe_n_i,
    input  logic ready_i,
    input  logic word_mode_i,
    output logic drv_lo_o,
    output logic drv_wide_o,
    output logic valid_o,
    output logic load_o
);
    localparam int  FLT_W     = (T_FLOAT < 2) ? 1 : $clog2(T_FLOAT + 1);
    localparam bit  HAS_FLOAT = (T_FLOAT > 0);
    localparam logic [FLT_W-1:0] FLT_LOAD = FLT_W'(T_FLOAT);

    port_state_e      state_q, state_d;
    logic [FLT_W-1:0] flt_q, flt_d;
    logic             word_q;
    logic             en;
    port_state_e      rel_st;
    port_state_e      run_st;

    assign en     = !ce_n_i && !oe_n_i;
    assign rel_st = ce_n_i ? ST_STANDBY : ST_OUTOFF;
    assign run_st = ready_i ? ST_VALID : ST_WAIT;

    // next state
    always_comb begin
        state_d = state_q;
        flt_d   = flt_q;
        unique case (state_q)
            ST_STANDBY, ST_OUTOFF: begin
                state_d = en ? run_st : rel_st;
            end
            ST_WAIT, ST_VALID: begin
                if (en) begin
                    state_d = run_st;
                end else if (HAS_FLOAT) begin
                    state_d = ST_FLOAT;
                    flt_d   = FLT_LOAD;
                end else begin
                    state_d = rel_st;
                end
            end
            ST_FLOAT: begin
                if (en) begin
                    state_d = run_st;
                end else if (flt_q <= FLT_W'(1)) begin
                    state_d = rel_st;
                end else begin
                    flt_d = flt_q - FLT_W'(1);
                end
            end
            default: state_d = ST_STANDBY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
            flt_q   <= '0;
            word_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            flt_q   <= flt_d;
            word_q  <= word_mode_i;
        end
    end

    // outputs
    always_comb begin
        drv_lo_o = 1'b0;
        valid_o  = 1'b0;
        unique case (state_q)
            ST_WAIT:  drv_lo_o = 1'b1;
            ST_VALID: begin
                drv_lo_o = 1'b1;
                valid_o  = 1'b1;
            end
            ST_FLOAT: drv_lo_o = 1'b1;
            default: begin
                drv_lo_o = 1'b0;
                valid_o  = 1'b0;
            end
        endcase
        drv_wide_o = drv_lo_o && word_q;
    end

    assign load_o = en && ready_i;

endmodule

// File: rtl/cfgw_rom_port.sv
module cfgw_rom_port
    import cfgw_rom_pkg::*;
#(
    parameter int ADDR_W        = 21,
    parameter int DEPTH         = 64,
    parameter int PRELOAD_WORDS = 48,
    parameter int T_ADDR        = 6,
    parameter int T_CE          = 5,
    parameter int T_OE          = 3,
    parameter int T_FLOAT       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              a_m1_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              word_mode_i,
    input  logic              id_force_i,
    output logic [15:0]       dq_o,
    output logic              drv_lo_o,
    output logic              drv_mid_o,
    output logic              drv_top_o,
    output logic              valid_o
);
    localparam int KEY_W = ADDR_W + 3;

    logic [KEY_W-1:0] key_now, key_q;
    logic             key_chg;
    logic             addr_met, ce_met, oe_met, ready;
    logic [15:0]      rd_word, id_word, src_word, shown;
    logic [15:0]      dq_q;
    logic             drv_wide, load;

    // access-key tracking: the half select only counts in byte mode
    assign key_now = {id_force_i, word_mode_i, (!word_mode_i && a_m1_i), addr_i};
    assign key_chg = (key_now != key_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
        end else begin
            key_q <= key_now;
        end
    end

    cfgw_age_counter #(.LIMIT(T_ADDR)) u_age_addr (
        .clk(clk), .rst_n(rst_n), .clear_i(1'b0), .restart_i(key_chg), .met_o(addr_met)
    );
    cfgw_age_counter #(.LIMIT(T_CE)) u_age_ce (
        .clk(clk), .rst_n(rst_n), .clear_i(ce_n_i), .restart_i(1'b0), .met_o(ce_met)
    );
    cfgw_age_counter #(.LIMIT(T_OE)) u_age_oe (
        .clk(clk), .rst_n(rst_n), .clear_i(oe_n_i), .restart_i(1'b0), .met_o(oe_met)
    );

    assign ready = addr_met && ce_met && oe_met;

    cfgw_rom_cells #(
        .ADDR_W(ADDR_W), .DEPTH(DEPTH), .PRELOAD_WORDS(PRELOAD_WORDS)
    ) u_cells (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_word_o(rd_word)
    );

    // identification codes: only a clean address 0 or 1 yields a code
    always_comb begin
        if (addr_i[ADDR_W-1:1] != '0) begin
            id_word = 16'h0000;
        end else begin
            id_word = {8'h00, addr_i[0] ? PART_CODE : MAKER_CODE};
        end
    end

    assign src_word = id_force_i ? id_word : rd_word;
    assign shown    = word_mode_i ? src_word
                                  : {8'h00, a_m1_i ? src_word[15:8] : src_word[7:0]};

    cfgw_port_fsm #(.T_FLOAT(T_FLOAT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
        .ready_i(ready), .word_mode_i(word_mode_i),
        .drv_lo_o(drv_lo_o), .drv_wide_o(drv_wide), .valid_o(valid_o), .load_o(load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_q <= '0;
        end else if (load) begin
            dq_q <= shown;
        end
    end

    assign dq_o      = dq_q;
    assign drv_mid_o = drv_wide;
    assign drv_top_o = drv_wide;

endmodule

// File: rtl/cfgw_rom_port_chk.sv
module cfgw_rom_port_chk #(
    parameter int ADDR_W  = 21,
    parameter int T_ADDR  = 6,
    parameter int T_FLOAT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ce_n_i,
    input logic              oe_n_i,
    input logic              word_mode_i,
    input logic              id_force_i,
    input logic [7:0]        dq_hi,
    input logic              drv_lo_o,
    input logic              drv_mid_o,
    input logic              valid_o
);
    localparam int RUN_W = $clog2(T_FLOAT + 3);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(T_FLOAT + 1);

    logic [RUN_W-1:0] ce_hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_hi_run <= '0;
        end else if (!ce_n_i) begin
            ce_hi_run <= '0;
        end else if (ce_hi_run < RUN_MAX) begin
            ce_hi_run <= ce_hi_run + RUN_W'(1);
        end
    end

    AST_VALID_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> drv_lo_o); // R2

    AST_WIDE_ONLY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        drv_mid_o |-> $past(word_mode_i)); // R4

    AST_VALID_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(!ce_n_i && !oe_n_i)); // R5

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_hi_run == RUN_MAX) |-> !drv_lo_o); // R7

    AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(id_force_i)) |-> (dq_hi == 8'h00)); // R9

    generate
        if (T_ADDR > 1) begin : g_addr_chk
            AST_ADDR_CHANGE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(addr_i) != $past(addr_i, 2)) |-> !valid_o); // R8
        end
    endgenerate

endmodule

bind cfgw_rom_port cfgw_rom_port_chk #(
    .ADDR_W(ADDR_W), .T_ADDR(T_ADDR), .T_FLOAT(T_FLOAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
    .word_mode_i(word_mode_i), .id_force_i(id_force_i), .dq_hi(dq_o[15:8]),
    .drv_lo_o(drv_lo_o), .drv_mid_o(drv_mid_o), .valid_o(valid_o)
);

// File: tb/cfgw_rom_port_tb.sv
`timescale 1ns/1ps
module cfgw_rom_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] addr_i = '0;
    logic        a_m1_i = 1'b0;
    logic        ce_n_i = 1'b1;
    logic        oe_n_i = 1'b1;
    logic        word_mode_i = 1'b1;
    logic        id_force_i = 1'b0;
    logic [15:0] dq_o;
    logic        drv_lo_o, drv_mid_o, drv_top_o, valid_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cfgw_rom_port u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .a_m1_i(a_m1_i),
        .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .word_mode_i(word_mode_i),
        .id_force_i(id_force_i), .dq_o(dq_o), .drv_lo_o(drv_lo_o),
        .drv_mid_o(drv_mid_o), .drv_top_o(drv_top_o), .valid_o(valid_o)
    );

    // expected array content, from R10
    function automatic logic [15:0] exp_word(input int idx);
        logic [7:0] b;
        if (idx >= 48) return 16'hFFFF;
        b = 8'(idx);
        return {b ^ 8'hA5, b + 8'h3C};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance n rising edges, then settle on the next falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 valid in reset", 16'(valid_o), 16'h0);
        check("R1 lanes in reset", {13'h0, drv_lo_o, drv_mid_o, drv_top_o}, 16'h0);
        rst_n = 1'b1;
        step(1);
        check("R1 lanes after reset", {13'h0, drv_lo_o, drv_mid_o, drv_top_o}, 16'h0);
        check("R1 valid after reset", 16'(valid_o), 16'h0);
    endtask

    task automatic t_word_read;
        addr_i = 21'd5; word_mode_i = 1'b1; ce_n_i = 1'b0; oe_n_i = 1'b0;
        step(5);
        check("R2 not valid before access time", 16'(valid_o), 16'h0);
        check("R2 drivers on while waiting", 16'(drv_lo_o), 16'h1);
        step(1);
        check("R2 valid at access time", 16'(valid_o), 16'h1);
        check("R3 word data", dq_o, exp_word(5));
        check("R3 all lanes driven", {13'h0, drv_lo_o, drv_mid_o, drv_top_o}, 16'h7);
    endtask

    task automatic t_addr_change;
        addr_i = 21'd42;
        step(1);
        check("R8 valid drops on address change", 16'(valid_o), 16'h0);
        step(4);
        check("R8 still settling", 16'(valid_o), 16'h0);
        step(1);
        check("R8 valid after T_ADDR", 16'(valid_o), 16'h1);
        check("R10 preloaded word 42", dq_o, exp_word(42));
    endtask

    task automatic t_oe_release;
        oe_n_i = 1'b1;
        step(1);
        check("R7 valid drops on release", 16'(valid_o), 16'h0);
        check("R7 drivers held in float", 16'(drv_lo_o), 16'h1);
        step(1);
        check("R7 drivers held second cycle", 16'(drv_lo_o), 16'h1);
        step(1);
        check("R6 drivers off with gate closed", {13'h0, drv_lo_o, drv_mid_o, drv_top_o}, 16'h0);
        oe_n_i = 1'b0;
        step(2);
        check("R6 not valid before T_OE", 16'(valid_o), 16'h0);
        step(1);
        check("R6 valid after T_OE", 16'(valid_o), 16'h1);
        check("R6 data after reopen", dq_o, exp_word(42));
    endtask

    task automatic t_byte;
        word_mode_i = 1'b0; a_m1_i = 1'b0; addr_i = 21'd5;
        step(6);
        check("R4 byte valid", 16'(valid_o), 16'h1);
        check("R4 low byte", dq_o, {8'h00, exp_word(5) & 16'h00FF});
        check("R4 upper lanes off", {14'h0, drv_mid_o, drv_top_o}, 16'h0);
        check("R4 low lane on", 16'(drv_lo_o), 16'h1);
        a_m1_i = 1'b1;
        step(1);
        check("R8 half select change drops valid", 16'(valid_o), 16'h0);
        step(5);
        check("R4 high byte", dq_o, {8'h00, exp_word(5) >> 8});
        check("R4 high byte valid", 16'(valid_o), 16'h1);
    endtask

    task automatic t_standby;
        word_mode_i = 1'b1; addr_i = 21'd7;
        step(6);
        check("R3 word 7", dq_o, exp_word(7));
        ce_n_i = 1'b1;
        step(1);
        check("R7 valid drops on deselect", 16'(valid_o), 16'h0);
        step(2);
        check("R5 standby lanes off", {13'h0, drv_lo_o, drv_mid_o, drv_top_o}, 16'h0);
        oe_n_i = 1'b1;
        step(1);
        oe_n_i = 1'b0;
        step(2);
        check("R5 output gate ignored in standby", {12'h0, valid_o, drv_lo_o, drv_mid_o, drv_top_o}, 16'h0);
        ce_n_i = 1'b0;
        step(4);
        check("R2 not valid before T_CE", 16'(valid_o), 16'h0);
        step(1);
        check("R2 valid after T_CE", 16'(valid_o), 16'h1);
    endtask

    task automatic t_ident;
        id_force_i = 1'b1; addr_i = 21'd0;
        step(6);
        check("R9 maker code", dq_o, 16'h0020);
        addr_i = 21'd1;
        step(6);
        check("R9 part code", dq_o, 16'h0032);
        addr_i = 21'd3;
        step(6);
        check("R9 other line high", dq_o, 16'h0000);
        id_force_i = 1'b0;
        step(6);
        check("R9 leaving code mode", dq_o, exp_word(3));
    endtask

    task automatic t_erased;
        addr_i = 21'd50;
        step(6);
        check("R10 erased above preload", dq_o, 16'hFFFF);
        addr_i = 21'h100000;
        step(6);
        check("R10 erased beyond depth", dq_o, 16'hFFFF);
        addr_i = 21'd0;
        step(6);
        check("R10 word 0", dq_o, exp_word(0));
    endtask

    initial begin
        step(3);
        t_reset();
        t_word_read();
        t_addr_change();
        t_oe_release();
        t_byte();
        t_standby();
        t_ident();
        t_erased();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule